// File: doc/BRIEF.md
# Master SPI Mode of a UART-Style Serial Block

This block is a serial port that, when its control register selects the master SPI mode, shifts one byte at a time. It drives a serial clock and a data output, and it samples a data input. Software reaches it through a four-address register port. Address 0 is control, addresses 1 and 2 hold the baud-rate divider, and address 3 holds data. A write to address 3 queues a byte to send, and a read of address 3 returns the last byte received. Two flag outputs report that the transmit buffer is free and that a received byte is waiting.

The serial clock comes from a 12-bit divider that is shared with the UART modes. Each half-period of the serial clock lasts divider+1 system cycles. The control register selects the clock polarity, the clock phase and the bit order. These settings are captured when a transfer starts, so a single control write can enable the mode and configure it, and a change made during a transfer only applies to the next one. The asynchronous mode, the synchronous mode and the reserved mode codes keep the engine idle. Leaving the SPI mode during a transfer cancels that transfer.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, control reads 8'h06 (mode 00, order bit 2 = 1, phase bit 1 = 1, polarity bit 0 = 0). At reset `tx_empty`=1, `rx_ready`=0, `sck`=0 and `sdo`=1.
- R2: Control bits 7:6 select the mode. Only code 11 runs the engine. With codes 00, 01 and 10 a queued byte stays queued (`tx_empty`=0) and `sck` does not toggle. Switching to 11 then starts the transfer.
- R3: Control bit 2 = 1 shifts the least significant bit first, in both directions. Bit 2 = 0 shifts the most significant bit first.
- R4: With control bit 1 = 0, `sdi` is sampled on the leading clock edge, and the first data bit is on `sdo` before that edge. With bit 1 = 1, `sdo` changes on the leading edge and `sdi` is sampled on the trailing edge. A transfer has 16 clock edges.
- R5: Control bit 0 sets the idle level of `sck`, and the first edge of a transfer moves away from that level.
- R6: Control bits 5:3 read as 0, and writes to them have no effect.
- R7: Address 1 holds divider bits 7:0 and address 2 holds bits 11:8 in its low nibble, and both read back. Consecutive `sck` edges within a transfer are divider+1 cycles apart.
- R8: At the end of a transfer `rx_ready` rises and the received byte can be read at address 3. A read of address 3 clears `rx_ready`.
- R9: `tx_empty` rises when a queued byte enters the shifter and falls only on a write to address 3. A byte queued during a transfer starts next, and its first edge comes divider+3 cycles after the previous transfer's last edge.
- R10: Mode, order, phase and polarity can all be set in one control write, and they are latched when a transfer starts. A change written during a transfer does not alter that transfer.
- R11: If the mode leaves 11 during a transfer, the transfer stops one cycle later and `sck` returns to the polarity level. `rx_ready` is not set, and the byte is not resent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 divider low, 2 divider high, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading data clears `rx_ready`) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_ready | output | 1 | A received byte is waiting |
| tx_empty | output | 1 | The transmit buffer can take a byte |

## Verification
The hardest cases to reach are the ones that hit the engine in the middle of a byte: a control write that changes order and polarity, or leaves the SPI mode, after a known number of clock edges. The bench acts as an SPI slave. It follows `sck` edge by edge, so it can issue the register write exactly after the sixth edge, or cancel the transfer once a fixed number of cycles have passed. Back-to-back transfers are produced by queuing the second byte as soon as `tx_empty` shows that the first byte has been taken.

// File: rtl/usart_spi_master.sv
module usart_spi_master #(
  parameter int DIVW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sck,
  output logic       sdo,
  input  logic       sdi,
  output logic       rx_ready,
  output logic       tx_empty
);
  localparam int HIW = DIVW - 8;
  localparam int EW  = 5;
  localparam logic [EW-1:0] LAST = 5'd16;

  logic [1:0]      mode;
  logic            lsb_first, phase, pol;
  logic [7:0]      div_lo;
  logic [HIW-1:0]  div_hi;
  logic [DIVW-1:0] div, div_cnt;
  logic [7:0]      tx_buf, tx_word, rx_sh, rx_buf;
  logic            tx_full, busy, sck_q;
  logic [EW-1:0]   edges, pos;
  logic            c_lsb, c_pha;
  logic            spi_on, start, tick, done, sample_now, rd_data;
  logic [2:0]      bitn;

  assign div        = {div_hi, div_lo};
  assign spi_on     = (mode == 2'b11);
  assign start      = spi_on && !busy && tx_full;
  assign tick       = busy && spi_on && (edges < LAST) && (div_cnt >= div);
  assign done       = busy && spi_on && (edges == LAST);
  assign sample_now = tick && (edges[0] == c_pha);
  assign rd_data    = reg_rd && (reg_addr == 2'd3);
  assign pos        = (c_pha && edges != '0) ? edges - 5'd1 : edges;
  assign bitn       = 3'(pos >> 1);
  assign sdo        = busy ? tx_word[c_lsb ? bitn : 3'd7 - bitn] : 1'b1;
  assign sck        = sck_q;
  assign tx_empty   = !tx_full;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {mode, 3'b000, lsb_first, phase, pol};
      2'd1:    reg_rdata = div_lo;
      2'd2:    reg_rdata = {{(8-HIW){1'b0}}, div_hi};
      default: reg_rdata = rx_buf;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= 2'b00;
      lsb_first <= 1'b1;
      phase     <= 1'b1;
      pol       <= 1'b0;
      div_lo    <= '0;
      div_hi    <= '0;
      tx_buf    <= '0;
      tx_full   <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            mode      <= reg_wdata[7:6];
            lsb_first <= reg_wdata[2];
            phase     <= reg_wdata[1];
            pol       <= reg_wdata[0];
          end
          2'd1:    div_lo <= reg_wdata;
          2'd2:    div_hi <= reg_wdata[HIW-1:0];
          default: tx_buf <= reg_wdata;
        endcase
      end
      if (reg_wr && reg_addr == 2'd3) tx_full <= 1'b1;
      else if (start)                 tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edges    <= '0;
      div_cnt  <= '0;
      sck_q    <= 1'b0;
      tx_word  <= '0;
      rx_sh    <= '0;
      rx_buf   <= '0;
      rx_ready <= 1'b0;
      c_lsb    <= 1'b1;
      c_pha    <= 1'b1;
    end else begin
      if (rd_data) rx_ready <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        edges   <= '0;
        div_cnt <= '0;
        tx_word <= tx_buf;
        c_lsb   <= lsb_first;
        c_pha   <= phase;
        sck_q   <= pol;
      end else if (busy && !spi_on) begin
        busy  <= 1'b0;
        edges <= '0;
        sck_q <= pol;
      end else if (done) begin
        busy     <= 1'b0;
        edges    <= '0;
        rx_buf   <= rx_sh;
        rx_ready <= 1'b1;
        sck_q    <= pol;
      end else if (tick) begin
        div_cnt <= '0;
        edges   <= edges + 5'd1;
        sck_q   <= ~sck_q;
        if (sample_now) rx_sh <= c_lsb ? {sdi, rx_sh[7:1]} : {rx_sh[6:0], sdi};
      end else if (busy) begin
        div_cnt <= div_cnt + DIVW'(1);
      end else begin
        sck_q <= pol;
      end
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_on) |=> (!busy && sck == $past(pol)));

  // R7
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spi_on && !tick && !done) |=> $stable(sck));

  // R8
  rx_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> ($past(busy) && $past(edges) == LAST));

  // R9
  tx_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(reg_wr && reg_addr == 2'd3));

  // R2
  start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(spi_on));

  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= LAST);
endmodule

// File: tb/test_usart_spi_master.sv
module test_usart_spi_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, sdi = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck, sdo, rx_ready, tx_empty;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  usart_spi_master i_usart_spi_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .sdo(sdo), .sdi(sdi),
    .rx_ready(rx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit bit_at(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  function automatic logic [7:0] ctrl_seen(input logic [7:0] w);
    return w & 8'hC7;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic watch(input int n, output int tg);
    logic p;
    tg = 0; p = sck;
    repeat (n) begin
      @(negedge clk);
      if (sck != p) tg++;
      p = sck;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input bit lsb, input bit cpha,
                      input bit cpol, input logic [11:0] div, input bit chg, input logic [7:0] chgval);
    logic [7:0] got, r;
    int edges, gap, badgap;
    logic p, p_sdo;
    wr(2'd1, div[7:0]);
    wr(2'd2, {4'b0000, div[11:8]});
    wr(2'd0, {2'b11, 3'b000, lsb, cpha, cpol});
    @(negedge clk);
    chk(sck == cpol, "R5 idle level", sck, cpol);
    if (!cpha) sdi = bit_at(slv, 0, lsb);
    wr(2'd3, tx);
    edges = 0; gap = 0; badgap = 0; got = '0; p = sck; p_sdo = sdo;
    for (int t = 0; t < 20 * (int'(div) + 2) && edges < 16; t++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      gap++;
      if (sck != p) begin
        if (edges == 0) begin
          chk(sck != cpol, "R5 first edge leaves idle level", sck, !cpol);
          if (!cpha) chk(p_sdo == bit_at(tx, 0, lsb), "R4 first bit ahead of leading edge", p_sdo, bit_at(tx, 0, lsb));
        end else if (gap != int'(div) + 1) badgap++;
        if ((edges % 2) == int'(cpha)) got[lsb ? edges/2 : 7 - edges/2] = sdo;
        else if ((edges + 1) / 2 < 8) sdi = bit_at(slv, (edges + 1) / 2, lsb);
        if (chg && edges == 5) begin reg_addr = 2'd0; reg_wdata = chgval; reg_wr = 1'b1; end
        edges++; gap = 0; p = sck;
      end
      p_sdo = sdo;
    end
    chk(edges == 16, "R4 sixteen clock edges", edges, 16);
    chk(badgap == 0, "R7 half period is divider+1", badgap, 0);
    repeat (3) @(negedge clk);
    chk(rx_ready == 1'b1, "R8 rx_ready set at end", rx_ready, 1);
    chk(tx_empty == 1'b1, "R9 buffer free after start", tx_empty, 1);
    chk(got == tx, $sformatf("R3 R4 slave saw sent byte lsb=%0d cpha=%0d", lsb, cpha), got, tx);
    rd(2'd3, r);
    chk(r == slv, $sformatf("R3 R4 received byte lsb=%0d cpha=%0d", lsb, cpha), r, slv);
    chk(rx_ready == 1'b0, "R8 read clears rx_ready", rx_ready, 0);
    chk(sck == (chg ? chgval[0] : cpol), "R5 R10 idle level after transfer", sck, chg ? chgval[0] : cpol);
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int tg, edges, gap, gap16;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_empty == 1'b1, "R1 tx_empty at reset", tx_empty, 1);
    chk(rx_ready == 1'b0, "R1 rx_ready at reset", rx_ready, 0);
    chk(sck == 1'b0, "R1 sck at reset", sck, 0);
    chk(sdo == 1'b1, "R1 sdo idle at reset", sdo, 1);
    rd(2'd0, r);
    chk(r == 8'h06, "R1 control reset value", r, 8'h06);

    // R6 reserved bits
    wr(2'd0, 8'h38); rd(2'd0, r);
    chk(r == ctrl_seen(8'h38), "R6 reserved bits read zero", r, ctrl_seen(8'h38));
    wr(2'd0, 8'h3E); rd(2'd0, r);
    chk(r == ctrl_seen(8'h3E), "R6 reserved bits ignored", r, ctrl_seen(8'h3E));

    // R7 divider readback
    wr(2'd1, 8'hAB); wr(2'd2, 8'hFC);
    rd(2'd2, r); chk(r == 8'h0C, "R7 divider high readback", r, 8'h0C);
    rd(2'd1, r); chk(r == 8'hAB, "R7 divider low readback", r, 8'hAB);

    // R2 non-SPI modes stay idle
    for (int m = 0; m < 3; m++) begin
      wr(2'd1, 8'd2); wr(2'd2, 8'd0);
      wr(2'd0, {2'(m), 6'b000110});
      wr(2'd3, 8'h5A);
      watch(60, tg);
      chk(tg == 0, $sformatf("R2 no clock in mode %0d", m), tg, 0);
      chk(tx_empty == 1'b0, "R2 byte stays queued", tx_empty, 0);
      wr(2'd0, 8'hC6);
      watch(60, tg);
      chk(tg == 16, "R2 mode 11 starts queued byte", tg, 16);
      rd(2'd3, r);
    end

    // directed transfers
    xfer(8'h96, 8'h3C, 1'b0, 1'b0, 1'b0, 12'h105, 1'b0, 8'h00);
    xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b1, 12'h000, 1'b0, 8'h00);
    xfer(8'hF0, 8'h0F, 1'b0, 1'b1, 1'b0, 12'h001, 1'b0, 8'h00);
    // R10 mid-transfer change applies only afterwards
    xfer(8'hC3, 8'h81, 1'b1, 1'b1, 1'b0, 12'h007, 1'b1, 8'hC1);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a, b;
      logic [2:0] cfg;
      a = 8'($urandom); b = 8'($urandom); cfg = 3'($urandom);
      xfer(a, b, cfg[2], cfg[1], cfg[0], 12'($urandom % 6), 1'b0, 8'h00);
    end

    // R9 back to back
    sdi = 1'b1;
    wr(2'd1, 8'd2); wr(2'd2, 8'd0); wr(2'd0, 8'hC0);
    wr(2'd3, 8'h11);
    for (int t = 0; t < 5 && !tx_empty; t++) @(negedge clk);
    chk(tx_empty == 1'b1, "R9 first byte taken", tx_empty, 1);
    wr(2'd3, 8'h22);
    chk(tx_empty == 1'b0, "R9 second byte queued", tx_empty, 0);
    edges = 0; gap = 0; gap16 = 0;
    begin
      logic p;
      p = sck;
      for (int t = 0; t < 400 && edges < 32; t++) begin
        @(negedge clk); gap++;
        if (sck != p) begin
          if (edges == 16) gap16 = gap;
          edges++; gap = 0; p = sck;
        end
      end
    end
    chk(edges == 32, "R9 two transfers ran", edges, 32);
    chk(gap16 == 5, "R9 back-to-back gap is divider+3", gap16, 5);
    repeat (4) @(negedge clk);
    rd(2'd3, r);
    chk(r == 8'hFF, "R8 second byte received", r, 8'hFF);

    // R11 abort
    wr(2'd1, 8'd3); wr(2'd2, 8'd0); wr(2'd0, 8'hC1);
    wr(2'd3, 8'hA5);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk(sck == 1'b1, "R11 clock back to idle on abort", sck, 1);
    watch(80, tg);
    chk(tg == 0, "R11 no edges after abort", tg, 0);
    chk(rx_ready == 1'b0, "R11 no completion on abort", rx_ready, 0);
    wr(2'd0, 8'hC1);
    watch(40, tg);
    chk(tg == 0, "R11 aborted byte not resent", tg, 0);
    chk(tx_empty == 1'b1, "R11 buffer stays empty", tx_empty, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule